// File: doc/BRIEF.md
# Two-Wire Single-Slave Bus Controller Register Front-End

This block is the software-visible side of a push-pull two-wire controller that talks to exactly one slave. A host reaches it through a plain 32-bit register port: a write strobe with address and data, and a read data bus that returns the addressed register one clock after the address is presented. The front-end holds the transfer setup (slave register addresses, byte count, direction, outgoing data), the serial clock divider and data output delay, the manual line overrides, and an interrupt status with per-bit enables and a global enable.

Software fills in the address, length and data registers and then sets the launch bit in the control register. The front-end sends a one-cycle start pulse to the serial engine and keeps the launch bit reading as 1 until the engine reports completion, which software takes as "bus busy". Completion sets a done flag or an error flag with an error code; on a successful read the returned bytes are loaded into the data registers. A second launch during a transfer only raises a load-busy flag. An abort request is handed to the engine and takes effect at the next byte boundary, where it ends the transfer as an error. A soft-reset bit returns the whole block to its defaults and pulses a reset to the engine.

Top module: `twi_regfront`

## Requirements
- R1: After reset every register reads 0 (except the live line bits of the line register), the interrupt output is low and no start pulse is issued.
- R2: Writing 1 to bit 7 of the control register (offset 0x00) while idle makes `eng_start` high for exactly one cycle, starting on the cycle after the write, and bit 7 then reads 1 until the transfer ends.
- R3: An engine completion without error sets status bit 0 (status offset 0x0C); with error it sets status bit 1 and loads the error code into status bits [15:8]; either way control bit 7 reads 0 afterwards.
- R4: Writing 1 to control bit 7 while a transfer runs sets status bit 2, issues no new start pulse and leaves bit 7 at 1.
- R5: Writing 1 to a status bit clears it, writing 0 leaves it unchanged; clearing bit 1 also clears the error code.
- R6: `irq` is high, one cycle after the condition, exactly when control bit 1 (global enable) is set and some status bit [2:0] is set together with the same bit of the enable register (offset 0x08).
- R7: Writing 1 to control bit 0 resets all registers, status and any running transfer in that same clock edge, pulses `eng_srst` for one cycle, and bit 0 reads 0.
- R8: Writing 1 to control bit 6 during a transfer drives `eng_abort` high and reads back as bit 6; at the next `eng_byte_end` the transfer ends, bits 6 and 7 read 0 and status bit 1 is set with error code 0xFF. With no transfer running, the abort bit has no effect.
- R9: The length register (offset 0x18) holds the byte count minus one in bits [2:0], driven on `eng_len_m1`, and the read flag in bit 4, driven on `eng_read`; other bits read 0.
- R10: A read transfer that completes without error loads `eng_rdata` into the data words (low word at 0x1C, high word at 0x20); a write transfer leaves them unchanged.
- R11: The clock register (offset 0x04) drives the divider from bits [7:0] and the data output delay from bits [10:8]; the line register (offset 0x24) drives SDA override enable/value from bits 0/1 and SCL override enable/value from bits 2/3, and reads the live SDA and SCL inputs in bits 4 and 5.
- R12: Address words at 0x10 (low) and 0x14 (high) drive `eng_addr`, data words at 0x1C and 0x20 drive `eng_wdata`, each read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data of the address presented on the previous cycle |
| irq | output | 1 | Interrupt request |
| eng_start | output | 1 | One-cycle launch pulse to the serial engine |
| eng_abort | output | 1 | Stop request, held until the next byte boundary |
| eng_srst | output | 1 | One-cycle engine reset after a soft reset |
| eng_read | output | 1 | Transfer direction, 1 = read |
| eng_len_m1 | output | 3 | Byte count minus one |
| eng_addr | output | 64 | Slave register addresses |
| eng_wdata | output | 64 | Outgoing data bytes |
| eng_clk_div | output | 8 | Serial clock divider |
| eng_sda_dly | output | 3 | Data output delay |
| sda_ovr_en | output | 1 | SDA manual override enable |
| sda_ovr_val | output | 1 | SDA manual override level |
| scl_ovr_en | output | 1 | SCL manual override enable |
| scl_ovr_val | output | 1 | SCL manual override level |
| eng_done | input | 1 | Engine completion pulse |
| eng_err | input | 1 | Completion carries an error |
| eng_err_id | input | 8 | Error code that goes with `eng_err` |
| eng_byte_end | input | 1 | Engine has reached a byte boundary |
| eng_rdata | input | 64 | Bytes returned by a read |
| sda_in | input | 1 | Live SDA level |
| scl_in | input | 1 | Live SCL level |

## Verification
The bench aims at the launch bit while a transfer is already running: a design that relaunched would show a second start pulse and no load-busy flag. It completes transfers both as reads and writes, so a design that loaded the data words on every completion would overwrite the write data. Aborts are issued both during a transfer and at idle, which catches a design that ends the transfer at once instead of at the byte boundary or that lets an idle abort set an error. Soft reset is applied with status flags set and a transfer in flight, so any register left outside the reset shows up on readback, and the global enable is toggled with status pending to expose an interrupt that ignores it.

// File: rtl/twi_rf_pkg.sv
package twi_rf_pkg;
  // register byte offsets
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_CLK  = 'h04;
  localparam int OFS_IEN  = 'h08;
  localparam int OFS_IST  = 'h0C;
  localparam int ADR_BASE = 'h10;
  localparam int OFS_LEN  = 'h18;
  localparam int DAT_BASE = 'h1C;
  localparam int OFS_LINE = 'h24;

  // control bits
  localparam int CT_START = 7;
  localparam int CT_ABORT = 6;
  localparam int CT_GIE   = 1;
  localparam int CT_SRST  = 0;

  // status bits
  localparam int ST_OVER  = 0;
  localparam int ST_ERR   = 1;
  localparam int ST_LDB   = 2;
  localparam int ST_NBITS = 3;
  localparam int ST_IDLSB = 8;

  localparam int LEN_RDBIT = 4;
  localparam int CLK_DLYLSB = 8;
  localparam int LN_SDA_LIVE = 4;
  localparam int LN_SCL_LIVE = 5;
  localparam int LN_NCTL = 4;

  typedef struct packed {
    logic ok;
    logic fail;
    logic ldbusy;
  } xfer_evt_t;
endpackage

// File: rtl/twi_rf_xfer.sv
module twi_rf_xfer
  import twi_rf_pkg::*;
#(
  parameter int ID_W = 8,
  parameter logic [ID_W-1:0] ABORT_ID = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rst_any,
  input  logic            start_req,
  input  logic            abort_req,
  input  logic            eng_done,
  input  logic            eng_err,
  input  logic [ID_W-1:0] eng_err_id,
  input  logic            eng_byte_end,
  output logic            busy,
  output logic            abort_pend,
  output logic            eng_start,
  output xfer_evt_t       evt,
  output logic [ID_W-1:0] fail_id
);
  logic busy_q, abort_q, start_q;
  logic done_hit, abort_hit, finish;

  assign done_hit  = busy_q & eng_done;
  assign abort_hit = busy_q & abort_q & eng_byte_end & ~eng_done;
  assign finish    = done_hit | abort_hit;

  assign evt.ok     = done_hit & ~eng_err;
  assign evt.fail   = (done_hit & eng_err) | abort_hit;
  assign evt.ldbusy = busy_q & start_req;
  assign fail_id    = done_hit ? eng_err_id : ABORT_ID;

  always_ff @(posedge clk) begin
    if (rst_any) begin
      busy_q  <= 1'b0;
      abort_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= start_req & ~busy_q;
      if (finish) begin
        busy_q  <= 1'b0;
        abort_q <= 1'b0;
      end else begin
        if (start_req && !busy_q) busy_q <= 1'b1;
        if (abort_req && busy_q) abort_q <= 1'b1;
      end
    end
  end

  assign busy       = busy_q;
  assign abort_pend = abort_q;
  assign eng_start  = start_q;

  a_r2_start_one_cycle: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);
  a_r2_start_with_busy: assert property (@(posedge clk) disable iff (rst)
    start_q |-> busy_q);
  a_r4_no_relaunch: assert property (@(posedge clk) disable iff (rst)
    ($past(busy_q) && busy_q) |-> !start_q);
  a_r8_abort_needs_busy: assert property (@(posedge clk) disable iff (rst)
    abort_q |-> busy_q);
endmodule

// File: rtl/twi_rf_status.sv
module twi_rf_status
  import twi_rf_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rst_any,
  input  xfer_evt_t           evt,
  input  logic [ID_W-1:0]     fail_id,
  input  logic                clr_wr,
  input  logic [ST_NBITS-1:0] clr_mask,
  input  logic [ST_NBITS-1:0] ien,
  input  logic                gie,
  output logic [ST_NBITS-1:0] sts,
  output logic [ID_W-1:0]     err_id,
  output logic                irq
);
  logic [ST_NBITS-1:0] sts_q, set_v, clr_v;
  logic [ID_W-1:0]     id_q;
  logic                irq_q;

  always_comb begin
    set_v = '0;
    set_v[ST_OVER] = evt.ok;
    set_v[ST_ERR]  = evt.fail;
    set_v[ST_LDB]  = evt.ldbusy;
    clr_v = clr_wr ? clr_mask : '0;
  end

  always_ff @(posedge clk) begin
    if (rst_any) begin
      sts_q <= '0;
      id_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~clr_v) | set_v;
      if (evt.fail) id_q <= fail_id;
      else if (clr_v[ST_ERR]) id_q <= '0;
      irq_q <= gie & (|(sts_q & ien));
    end
  end

  assign sts    = sts_q;
  assign err_id = id_q;
  assign irq    = irq_q;

  a_r6_irq_needs_gie: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(gie));
  a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ($past(sts_q & ien) != '0));
  a_r3_id_follows_err: assert property (@(posedge clk) disable iff (rst)
    !sts_q[ST_ERR] |-> (id_q == '0));
endmodule

// File: rtl/twi_regfront.sv
module twi_regfront
  import twi_rf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter int WORDS = 2,
  parameter int LEN_W = 3,
  parameter int DIV_W = 8,
  parameter int DLY_W = 3,
  parameter int ID_W  = 8,
  parameter logic [ID_W-1:0] ABORT_ID = '1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wen,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic                irq,
  output logic                eng_start,
  output logic                eng_abort,
  output logic                eng_srst,
  output logic                eng_read,
  output logic [LEN_W-1:0]    eng_len_m1,
  output logic [WORDS*DW-1:0] eng_addr,
  output logic [WORDS*DW-1:0] eng_wdata,
  output logic [DIV_W-1:0]    eng_clk_div,
  output logic [DLY_W-1:0]    eng_sda_dly,
  output logic                sda_ovr_en,
  output logic                sda_ovr_val,
  output logic                scl_ovr_en,
  output logic                scl_ovr_val,
  input  logic                eng_done,
  input  logic                eng_err,
  input  logic [ID_W-1:0]     eng_err_id,
  input  logic                eng_byte_end,
  input  logic [WORDS*DW-1:0] eng_rdata,
  input  logic                sda_in,
  input  logic                scl_in
);
  localparam int WSTEP = DW / 8;

  logic wr_ctrl, wr_clk, wr_ien, wr_ist, wr_len, wr_line;
  logic srst_hit, rst_any, start_req, abort_req;
  logic gie_q, rd_q, srst_q, busy, abort_pend, cap;
  logic [ST_NBITS-1:0] ien_q, sts;
  logic [ID_W-1:0]     err_id, fail_id;
  logic [DIV_W-1:0]    div_q;
  logic [DLY_W-1:0]    dly_q;
  logic [LEN_W-1:0]    len_q;
  logic [LN_NCTL-1:0]  line_q;
  logic [DW-1:0]       adr_q [WORDS];
  logic [DW-1:0]       dat_q [WORDS];
  logic [DW-1:0]       rd_mux;
  xfer_evt_t           evt;

  assign wr_ctrl = bus_wen && (bus_addr == AW'(OFS_CTRL));
  assign wr_clk  = bus_wen && (bus_addr == AW'(OFS_CLK));
  assign wr_ien  = bus_wen && (bus_addr == AW'(OFS_IEN));
  assign wr_ist  = bus_wen && (bus_addr == AW'(OFS_IST));
  assign wr_len  = bus_wen && (bus_addr == AW'(OFS_LEN));
  assign wr_line = bus_wen && (bus_addr == AW'(OFS_LINE));

  assign srst_hit  = wr_ctrl & bus_wdata[CT_SRST];
  assign rst_any   = rst | srst_hit;
  assign start_req = wr_ctrl & bus_wdata[CT_START];
  assign abort_req = wr_ctrl & bus_wdata[CT_ABORT];
  assign cap       = evt.ok & rd_q;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst_any) begin
      gie_q  <= 1'b0;
      ien_q  <= '0;
      div_q  <= '0;
      dly_q  <= '0;
      len_q  <= '0;
      rd_q   <= 1'b0;
      line_q <= '0;
    end else begin
      if (wr_ctrl) gie_q <= bus_wdata[CT_GIE];
      if (wr_ien)  ien_q <= bus_wdata[ST_NBITS-1:0];
      if (wr_clk) begin
        div_q <= bus_wdata[DIV_W-1:0];
        dly_q <= bus_wdata[CLK_DLYLSB +: DLY_W];
      end
      if (wr_len) begin
        len_q <= bus_wdata[LEN_W-1:0];
        rd_q  <= bus_wdata[LEN_RDBIT];
      end
      if (wr_line) line_q <= bus_wdata[LN_NCTL-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) srst_q <= 1'b0;
    else     srst_q <= srst_hit;
  end

  // address and data words
  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic wr_adr, wr_dat;
    assign wr_adr = bus_wen && (bus_addr == AW'(ADR_BASE + WSTEP * i));
    assign wr_dat = bus_wen && (bus_addr == AW'(DAT_BASE + WSTEP * i));

    always_ff @(posedge clk) begin
      if (rst_any) begin
        adr_q[i] <= '0;
        dat_q[i] <= '0;
      end else begin
        if (wr_adr) adr_q[i] <= bus_wdata;
        if (cap)         dat_q[i] <= eng_rdata[i*DW +: DW];
        else if (wr_dat) dat_q[i] <= bus_wdata;
      end
    end

    assign eng_addr[i*DW +: DW]  = adr_q[i];
    assign eng_wdata[i*DW +: DW] = dat_q[i];
  end

  twi_rf_xfer #(.ID_W(ID_W), .ABORT_ID(ABORT_ID)) u_xfer (
    .clk(clk), .rst(rst), .rst_any(rst_any),
    .start_req(start_req), .abort_req(abort_req),
    .eng_done(eng_done), .eng_err(eng_err), .eng_err_id(eng_err_id),
    .eng_byte_end(eng_byte_end),
    .busy(busy), .abort_pend(abort_pend), .eng_start(eng_start),
    .evt(evt), .fail_id(fail_id)
  );

  twi_rf_status #(.ID_W(ID_W)) u_status (
    .clk(clk), .rst(rst), .rst_any(rst_any),
    .evt(evt), .fail_id(fail_id),
    .clr_wr(wr_ist), .clr_mask(bus_wdata[ST_NBITS-1:0]),
    .ien(ien_q), .gie(gie_q),
    .sts(sts), .err_id(err_id), .irq(irq)
  );

  // read mux, registered
  always_comb begin
    rd_mux = '0;
    if (bus_addr == AW'(OFS_CTRL)) begin
      rd_mux[CT_START] = busy;
      rd_mux[CT_ABORT] = abort_pend;
      rd_mux[CT_GIE]   = gie_q;
    end
    if (bus_addr == AW'(OFS_CLK)) begin
      rd_mux[DIV_W-1:0]          = div_q;
      rd_mux[CLK_DLYLSB +: DLY_W] = dly_q;
    end
    if (bus_addr == AW'(OFS_IEN)) rd_mux[ST_NBITS-1:0] = ien_q;
    if (bus_addr == AW'(OFS_IST)) begin
      rd_mux[ST_NBITS-1:0]     = sts;
      rd_mux[ST_IDLSB +: ID_W] = err_id;
    end
    if (bus_addr == AW'(OFS_LEN)) begin
      rd_mux[LEN_W-1:0] = len_q;
      rd_mux[LEN_RDBIT] = rd_q;
    end
    if (bus_addr == AW'(OFS_LINE)) begin
      rd_mux[LN_NCTL-1:0] = line_q;
      rd_mux[LN_SDA_LIVE] = sda_in;
      rd_mux[LN_SCL_LIVE] = scl_in;
    end
    for (int i = 0; i < WORDS; i++) begin
      if (bus_addr == AW'(ADR_BASE + WSTEP * i)) rd_mux = adr_q[i];
      if (bus_addr == AW'(DAT_BASE + WSTEP * i)) rd_mux = dat_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst_any) bus_rdata <= '0;
    else         bus_rdata <= rd_mux;
  end

  assign eng_abort   = abort_pend;
  assign eng_srst    = srst_q;
  assign eng_read    = rd_q;
  assign eng_len_m1  = len_q;
  assign eng_clk_div = div_q;
  assign eng_sda_dly = dly_q;
  assign sda_ovr_en  = line_q[0];
  assign sda_ovr_val = line_q[1];
  assign scl_ovr_en  = line_q[2];
  assign scl_ovr_val = line_q[3];

  a_r7_srst_clears_start: assert property (@(posedge clk) disable iff (rst)
    srst_q |-> !eng_start && !abort_pend);
  a_r10_capture_only_read: assert property (@(posedge clk) disable iff (rst)
    (evt.ok && !rd_q && !srst_hit && !(bus_wen && bus_addr == AW'(DAT_BASE)))
      |=> (dat_q[0] == $past(dat_q[0])));
endmodule

// File: tb/twi_regfront_bench.sv
module twi_regfront_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wen = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, eng_start, eng_abort, eng_srst, eng_read;
  logic [2:0]  eng_len_m1;
  logic [63:0] eng_addr, eng_wdata;
  logic [7:0]  eng_clk_div;
  logic [2:0]  eng_sda_dly;
  logic        sda_ovr_en, sda_ovr_val, scl_ovr_en, scl_ovr_val;
  logic        eng_done = 1'b0, eng_err = 1'b0, eng_byte_end = 1'b0;
  logic [7:0]  eng_err_id = '0;
  logic [63:0] eng_rdata = '0;
  logic        sda_in = 1'b0, scl_in = 1'b0;

  int errors = 0;
  int checks = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  twi_regfront u_twi_regfront (
    .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .eng_start(eng_start), .eng_abort(eng_abort), .eng_srst(eng_srst),
    .eng_read(eng_read), .eng_len_m1(eng_len_m1), .eng_addr(eng_addr),
    .eng_wdata(eng_wdata), .eng_clk_div(eng_clk_div), .eng_sda_dly(eng_sda_dly),
    .sda_ovr_en(sda_ovr_en), .sda_ovr_val(sda_ovr_val),
    .scl_ovr_en(scl_ovr_en), .scl_ovr_val(scl_ovr_val),
    .eng_done(eng_done), .eng_err(eng_err), .eng_err_id(eng_err_id),
    .eng_byte_end(eng_byte_end), .eng_rdata(eng_rdata),
    .sda_in(sda_in), .scl_in(scl_in)
  );

  // {addr, write data, expected readback}
  localparam logic [71:0] VEC [9] = '{
    {8'h04, 32'hFFFF_FFFF, 32'h0000_07FF},
    {8'h18, 32'hFFFF_FFFF, 32'h0000_0017},
    {8'h08, 32'hFFFF_FFFF, 32'h0000_0007},
    {8'h10, 32'h1234_5678, 32'h1234_5678},
    {8'h14, 32'h9ABC_DEF0, 32'h9ABC_DEF0},
    {8'h1C, 32'h0BAD_BEEF, 32'h0BAD_BEEF},
    {8'h20, 32'hFEED_FACE, 32'hFEED_FACE},
    {8'h24, 32'hFFFF_FFFF, 32'h0000_000F},
    {8'h00, 32'h0000_0002, 32'h0000_0002}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic finish_xfer(input logic err, input logic [7:0] id);
    eng_done = 1'b1; eng_err = err; eng_err_id = id;
    @(posedge clk); @(negedge clk);
    eng_done = 1'b0; eng_err = 1'b0; eng_err_id = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    rd(8'h00, rv); chk("R1 ctrl", rv, 0);
    rd(8'h0C, rv); chk("R1 status", rv, 0);
    rd(8'h04, rv); chk("R1 clk", rv, 0);
    rd(8'h1C, rv); chk("R1 data0", rv, 0);
    chk("R1 irq", irq, 0);
    chk("R1 start", eng_start, 0);

    // R9 R11 R12 register table
    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], rv);
      chk("R9/R11/R12 table", rv, VEC[i][31:0]);
    end
    chk("R9 len", eng_len_m1, 3'd7);
    chk("R9 read", eng_read, 1);
    chk("R11 div", eng_clk_div, 8'hFF);
    chk("R11 delay", eng_sda_dly, 3'd7);
    chk("R11 overrides", {scl_ovr_val, scl_ovr_en, sda_ovr_val, sda_ovr_en}, 4'hF);
    chk("R12 addr", eng_addr, 64'h9ABC_DEF0_1234_5678);
    chk("R12 wdata", eng_wdata, 64'hFEED_FACE_0BAD_BEEF);

    // R11 live lines
    sda_in = 1'b1; scl_in = 1'b0;
    rd(8'h24, rv); chk("R11 live sda", rv, 32'h1F);
    sda_in = 1'b0; scl_in = 1'b1;
    rd(8'h24, rv); chk("R11 live scl", rv, 32'h2F);

    // R2 launch
    wr(8'h00, 32'h82);
    chk("R2 start pulse", eng_start, 1);
    @(posedge clk); @(negedge clk);
    chk("R2 start single", eng_start, 0);
    rd(8'h00, rv); chk("R2 busy bit", rv, 32'h82);

    // R4 launch while busy
    wr(8'h00, 32'h82);
    chk("R4 no start", eng_start, 0);
    rd(8'h00, rv); chk("R4 still busy", rv, 32'h82);
    rd(8'h0C, rv); chk("R4 load busy", rv, 32'h4);
    chk("R6 irq on", irq, 1);

    // R5 write-one-to-clear
    wr(8'h0C, 32'h0);
    rd(8'h0C, rv); chk("R5 zero keeps", rv, 32'h4);
    wr(8'h0C, 32'h4);
    rd(8'h0C, rv); chk("R5 one clears", rv, 32'h0);
    chk("R6 irq off", irq, 0);

    // R3 R10 read completes
    eng_rdata = 64'hCAFE_F00D_1357_9BDF;
    finish_xfer(1'b0, 8'h00);
    rd(8'h00, rv); chk("R3 idle after done", rv, 32'h02);
    rd(8'h0C, rv); chk("R3 over bit", rv, 32'h1);
    rd(8'h1C, rv); chk("R10 captured low", rv, 32'h1357_9BDF);
    rd(8'h20, rv); chk("R10 captured high", rv, 32'hCAFE_F00D);
    chk("R6 irq over", irq, 1);
    wr(8'h0C, 32'h7);

    // R10 write transfer keeps data
    wr(8'h18, 32'h0);
    wr(8'h00, 32'h82);
    eng_rdata = 64'h1111_2222_3333_4444;
    finish_xfer(1'b0, 8'h00);
    rd(8'h1C, rv); chk("R10 write keeps data", rv, 32'h1357_9BDF);
    rd(8'h0C, rv); chk("R3 over write", rv, 32'h1);
    wr(8'h0C, 32'h7);

    // R3 error completion, R5 clears code
    wr(8'h00, 32'h82);
    finish_xfer(1'b1, 8'h5A);
    rd(8'h0C, rv); chk("R3 error and code", rv, 32'h5A02);
    rd(8'h00, rv); chk("R3 idle after error", rv, 32'h02);
    wr(8'h0C, 32'h2);
    rd(8'h0C, rv); chk("R5 code cleared", rv, 32'h0);

    // R6 global enable gates irq
    wr(8'h00, 32'h80);
    finish_xfer(1'b0, 8'h00);
    rd(8'h0C, rv); chk("R6 flag pending", rv, 32'h1);
    chk("R6 gie off", irq, 0);
    wr(8'h00, 32'h02);
    rd(8'h00, rv);
    chk("R6 gie on", irq, 1);
    wr(8'h0C, 32'h7);

    // R8 abort during transfer
    wr(8'h00, 32'h82);
    wr(8'h00, 32'h42);
    chk("R8 abort out", eng_abort, 1);
    rd(8'h00, rv); chk("R8 abort pending", rv, 32'hC2);
    rd(8'h0C, rv); chk("R8 no early end", rv, 32'h0);
    eng_byte_end = 1'b1;
    @(posedge clk); @(negedge clk);
    eng_byte_end = 1'b0;
    chk("R8 abort released", eng_abort, 0);
    rd(8'h00, rv); chk("R8 ended", rv, 32'h02);
    rd(8'h0C, rv); chk("R8 abort error", rv, 32'hFF02);
    wr(8'h0C, 32'h7);

    // R8 abort when idle
    wr(8'h00, 32'h42);
    chk("R8 idle abort out", eng_abort, 0);
    rd(8'h00, rv); chk("R8 idle abort ctrl", rv, 32'h02);
    rd(8'h0C, rv); chk("R8 idle abort status", rv, 32'h0);

    // R7 soft reset with transfer running and flag set
    wr(8'h00, 32'h82);
    wr(8'h00, 32'h82);
    rd(8'h0C, rv); chk("R7 setup flag", rv, 32'h4);
    wr(8'h00, 32'h01);
    chk("R7 engine reset", eng_srst, 1);
    @(posedge clk); @(negedge clk);
    chk("R7 engine reset single", eng_srst, 0);
    rd(8'h00, rv); chk("R7 ctrl", rv, 32'h0);
    rd(8'h0C, rv); chk("R7 status", rv, 32'h0);
    rd(8'h08, rv); chk("R7 enables", rv, 32'h0);
    rd(8'h04, rv); chk("R7 clk", rv, 32'h0);
    rd(8'h10, rv); chk("R7 addr0", rv, 32'h0);
    rd(8'h24, rv); chk("R7 line", rv, 32'h20);
    chk("R7 wdata", eng_wdata, 64'h0);
    chk("R7 irq", irq, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule